// File: doc/BRIEF.md
# Radio Interrupt Status Controller

This block gathers single-cycle event pulses from a packet radio core and turns them into one interrupt line for a host processor. Two event sources are handled: completion of a normal transmission and arrival of a received frame. Each source owns a bit in an 8-bit status register that latches the pulse until the host reads it. An 8-bit mask register holds one bit per status position. A mask bit of 1 blocks that source from the interrupt line and a mask bit of 0 lets it through. The interrupt output is active low, so a host that watches for a falling edge sees each new interrupt.

After reset every source is masked. The host first writes the mask register to enable the sources it wants. When the line goes low, the host reads the status register once with a one-cycle read strobe. That read returns every pending bit, so both events can be serviced together, and it clears them. The register transport (for example a serial bus bridge) and the radio datapath are outside this block. They appear here only as strobes. There is no streaming data path, so all pins are plain control and status signals.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x00, the mask reads 0xFF and irq_n_o is high.
- R2: A pulse on tx_done_i sets status bit 0 and a pulse on rx_done_i sets status bit 3, each visible after the next clock edge. Status bits 1, 2 and 4 to 7 always read 0.
- R3: A status bit latches its event even while its mask bit is 1, and while masked it does not pull irq_n_o low.
- R4: irq_n_o is low exactly when some status bit is 1 and its mask bit is 0. The state of irq_n_o after each clock edge matches the status and mask registers at that edge, so clearing a mask bit over a pending event drives the line low at the edge of that write.
- R5: While stat_rd_i is high, stat_rdata_o shows the pending bits, and at the clock edge that ends the strobe cycle the status register clears.
- R6: An event pulse in the same cycle as a status read stays pending after the clear.
- R7: With both events pending, one read returns 0x09 and clears both bits.
- R8: irq_n_o returns high at the clock edge where the last unmasked pending bit clears.
- R9: A mask write strobe loads all 8 bits of mask_wdata_i at the clock edge, and mask_o reads the stored value back. Without the strobe the mask holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 1 | One-cycle pulse: normal transmission finished |
| rx_done_i | input | 1 | One-cycle pulse: frame received |
| stat_rd_i | input | 1 | Status read strobe; clears status at the edge |
| stat_rdata_o | output | 8 | Current status register contents |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Value to load into the mask register |
| mask_o | output | 8 | Current mask register contents |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench aims at an event that arrives in the same cycle as a status read. A design that applies the clear with priority would drop that event, and the host would never hear about the frame or transmission. It also latches events while they are masked and then unmasks them. A design that gates the latch with the mask would lose the event, and a design that takes a cycle to register the new mask would leave the line high one edge too long. Reads with both events pending, and reads that remove the last unmasked bit, show whether the line rises at the clearing edge and whether one read reports both sources. Mask writes with random data, including writes to positions that have no source, show whether every stored bit reads back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int STAT_W  = 8;
  localparam int TX_POS  = 0;
  localparam int RX_POS  = 3;
  localparam logic [STAT_W-1:0] MASK_RST = '1;
endpackage

// File: rtl/irqc_evt_latch.sv
module irqc_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic stat_o,
  output logic nxt_o
);
  logic stat_q;

  // A new event wins over a clear in the same cycle.
  always_comb nxt_o = evt_i | (stat_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= nxt_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] mask_q;

  always_comb nxt_o = wr_i ? wdata_i : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= RST_VAL;
    else        mask_q <= nxt_o;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqc_irq_gen.sv
module irqc_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_nxt_i,
  input  logic [W-1:0] mask_nxt_i,
  output logic         irq_n_o
);
  logic irq_n_q;
  logic any_live;

  // Registered from next-state values: the line follows the registers with no lag
  // and changes only at clock edges.
  always_comb any_live = |(stat_nxt_i & ~mask_nxt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~any_live;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl #(
  parameter int W      = irqc_pkg::STAT_W,
  parameter int TX_POS = irqc_pkg::TX_POS,
  parameter int RX_POS = irqc_pkg::RX_POS,
  parameter logic [W-1:0] MASK_RST = irqc_pkg::MASK_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_done_i,
  input  logic         rx_done_i,
  input  logic         stat_rd_i,
  output logic [W-1:0] stat_rdata_o,
  input  logic         mask_wr_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] mask_o,
  output logic         irq_n_o
);
  logic [W-1:0] evt_vec;
  logic [W-1:0] stat_vec;
  logic [W-1:0] stat_nxt;
  logic [W-1:0] mask_nxt;

  always_comb begin
    evt_vec = '0;
    evt_vec[TX_POS] = tx_done_i;
    evt_vec[RX_POS] = evt_vec[RX_POS] | rx_done_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_stat
    if (i == TX_POS || i == RX_POS) begin : g_src
      irqc_evt_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_vec[i]),
        .clr_i  (stat_rd_i),
        .stat_o (stat_vec[i]),
        .nxt_o  (stat_nxt[i])
      );
    end else begin : g_none
      assign stat_vec[i] = 1'b0;
      assign stat_nxt[i] = 1'b0;
    end
  end

  irqc_mask_reg #(.W(W), .RST_VAL(MASK_RST)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_o),
    .nxt_o   (mask_nxt)
  );

  irqc_irq_gen #(.W(W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_nxt_i (stat_nxt),
    .mask_nxt_i (mask_nxt),
    .irq_n_o    (irq_n_o)
  );

  assign stat_rdata_o = stat_vec;
endmodule

// File: rtl/radio_irq_ctrl_chk.sv
module radio_irq_ctrl_chk #(
  parameter int W      = 8,
  parameter int TX_POS = 0,
  parameter int RX_POS = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_done_i,
  input logic         rx_done_i,
  input logic         stat_rd_i,
  input logic [W-1:0] stat_rdata_o,
  input logic         mask_wr_i,
  input logic [W-1:0] mask_wdata_i,
  input logic [W-1:0] mask_o,
  input logic         irq_n_o
);
  localparam logic [W-1:0] USED = (W'(1) << TX_POS) | (W'(1) << RX_POS);

  a_r2_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_i |=> stat_rdata_o[TX_POS]);
  a_r2_rx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> stat_rdata_o[RX_POS]);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata_o & ~USED) == '0);
  a_r3_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((stat_rdata_o & $past(stat_rdata_o)) == $past(stat_rdata_o)));
  a_r4_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_rdata_o & ~mask_o)) |-> !irq_n_o);
  a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rdata_o & ~mask_o) == '0) |-> irq_n_o);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !tx_done_i && !rx_done_i) |=> (stat_rdata_o == '0));
  a_r9_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> (mask_o == $past(mask_wdata_i)));
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_i |=> $stable(mask_o));
endmodule

bind radio_irq_ctrl radio_irq_ctrl_chk #(.W(W), .TX_POS(TX_POS), .RX_POS(RX_POS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_done_i    (tx_done_i),
  .rx_done_i    (rx_done_i),
  .stat_rd_i    (stat_rd_i),
  .stat_rdata_o (stat_rdata_o),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .mask_o       (mask_o),
  .irq_n_o      (irq_n_o)
);

// File: tb/radio_irq_ctrl_bench.sv
module radio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_done_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic [7:0] stat_rdata_o;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_wdata_i = 8'h00;
  logic [7:0] mask_o;
  logic       irq_n_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_stat = 8'h00;
  logic [7:0] m_mask = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_irq_ctrl u_radio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
    .stat_rd_i(stat_rd_i), .stat_rdata_o(stat_rdata_o), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .mask_o(mask_o), .irq_n_o(irq_n_o)
  );

  function automatic logic [7:0] f_stat(logic [7:0] s, logic tx, logic rx, logic rd);
    logic [7:0] ev;
    ev = {4'b0, rx, 2'b0, tx};
    return ev | (rd ? 8'h00 : s);
  endfunction

  function automatic logic f_irq_n(logic [7:0] s, logic [7:0] m);
    return ~|(s & ~m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle: inputs set after a falling edge, model updated at the
  // rising edge, outputs compared just after it.
  task automatic cycle(logic tx, logic rx, logic rd, logic wr, logic [7:0] wd, string req);
    @(negedge clk);
    tx_done_i = tx; rx_done_i = rx; stat_rd_i = rd; mask_wr_i = wr; mask_wdata_i = wd;
    #1;
    if (rd) check({req, " R5 read data"}, stat_rdata_o, m_stat);
    @(posedge clk);
    m_stat = f_stat(m_stat, tx, rx, rd);
    if (wr) m_mask = wd;
    #1;
    check({req, " status"}, stat_rdata_o, m_stat);
    check({req, " R9 mask"}, mask_o, m_mask);
    check({req, " R4 irq_n"}, irq_n_o, f_irq_n(m_stat, m_mask));
  endtask

  task automatic idle(string req);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    #(CLK_PERIOD * 3);
    #2;
    check("R1 status", stat_rdata_o, 8'h00);
    check("R1 mask", mask_o, 8'hFF);
    check("R1 irq_n", irq_n_o, 1'b1);
    rst_n = 1'b1;
    idle("R1");

    // R3: latched while masked, line stays high
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R2 R3 tx masked");
    check("R3 irq_n masked", irq_n_o, 1'b1);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R2 R3 rx masked");
    check("R2 both bits", stat_rdata_o, 8'h09);
    // R4: unmask rx only, line drops at that edge
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 8'hF7, "R4 unmask rx");
    check("R4 irq low on unmask", irq_n_o, 1'b0);
    // R7: one read returns both
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7 read both");
    check("R7 cleared", stat_rdata_o, 8'h00);
    check("R8 irq high after clear", irq_n_o, 1'b1);
    // R6: event in same cycle as read
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 8'hF6, "R4 unmask both");
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R6 rx during read");
    check("R6 rx kept", stat_rdata_o, 8'h08);
    check("R6 irq still low", irq_n_o, 1'b0);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R8 last clear");
    check("R8 irq high", irq_n_o, 1'b1);
    // R9: full-width mask write and hold
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R9 write");
    check("R9 readback", mask_o, 8'hA5);
    idle("R9 hold");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cycle(r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6], ($urandom % 8) == 0,
            8'($urandom), "R2 R4 R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule